// File: doc/BRIEF.md
# Vertical-Blanking Copy-Control and Aspect Data Inserter

This block sits in the luma path of a digital PAL/NTSC encoder. On a few chosen vertical-blanking lines it replaces the incoming 8-bit luma with a two-level data waveform. In NTSC mode it carries a 20-bit copy-control word, led by a fixed two-bit start pattern, on line 20 of the odd field and on line 283 of the even field. Each of those two lines has its own enable bit. In PAL mode it carries a 14-bit aspect-ratio word on line 23. On every other line, and outside the data window on the chosen lines, the luma passes through unchanged and with no delay.

The host loads payload and enable bits through a simple byte-write strobe into shadow registers. The shadow set is copied into the active set only on a field-start pulse, so a line never carries a mix of old and new bits. A small state machine with three states serialises the selected frame MSB first. ST_IDLE waits for the trigger sample. ST_COPY shifts out a copy-control frame. ST_WIDE shifts out an aspect frame. Each state returns to ST_IDLE after its last bit period. The two start transitions, ST_IDLE to ST_COPY and ST_IDLE to ST_WIDE, are taken when hcount equals WIN_START on a line whose number, field flag, standard and enable all match. No other transitions exist.

Top module: `vbi_copy_aspect_ins`

## Requirements
- R1: After reset all enables and payload bits are zero, and the output equals luma_in on every line, including lines 20, 283 and 23.
- R2: Host byte writes (wr_en high for one cycle) go to shadow registers. Address 0 holds the control byte: bit0 is the odd-line copy enable, bit1 is the even-line copy enable, bit2 is the aspect enable, and bits 7:4 are copy payload bits 3:0. Address 1 holds copy bits 11:4, address 2 holds copy bits 19:12, address 3 holds aspect bits 7:0, and address 4 bits 5:0 hold aspect bits 13:8.
- R3: The shadow registers are copied to the active set only in a cycle where field_start is high. Writes made during a field do not change what that field inserts.
- R4: With pal_mode low and the odd enable set, a copy frame is inserted on line 20 when field_odd is 1.
- R5: With pal_mode low and the even enable set, a copy frame is inserted on line 283 when field_odd is 0. The two enables act independently.
- R6: A copy frame is 22 bits long: the start bits 1 then 0, followed by payload bit 19 down to bit 0.
- R7: With pal_mode high and the aspect enable set, a 14-bit aspect frame (bit 13 first) is inserted on line 23, whatever the field flag.
- R8: In NTSC mode the aspect enable is ignored, and in PAL mode the copy enables are ignored; such lines pass luma through.
- R9: Bit value 1 outputs LVL_HI (default 169) and bit value 0 outputs LVL_LO (default 16). Each bit lasts BIT_CLKS samples. The first bit is output while hcount equals WIN_START+1, given that hcount advances by one per clock.
- R10: Luma passes through unchanged before and after the data window on chosen lines, and on all other lines.
- R11: A line number with the wrong field flag (line 20 with field_odd 0, line 283 with field_odd 1) carries no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_addr | input | 3 | Host register address |
| wr_data | input | 8 | Host write byte |
| field_start | input | 1 | Pulse at the start of each field; loads the active set |
| line_num | input | LINE_W (10) | Frame line number of the current line |
| field_odd | input | 1 | 1 during the odd field |
| pal_mode | input | 1 | 1 = PAL, 0 = NTSC |
| hcount | input | HCNT_W (11) | Horizontal sample counter |
| luma_in | input | PIX_W (8) | Incoming luma sample |
| luma_out | output | PIX_W (8) | Luma passed through or replaced by data levels |

## Verification
The bench covers several cases. A write made mid-field must leave that field's lines unchanged; a design that loads the active set at the write would put new bits on the line too early. Each field line is enabled on its own and run with the opposite field flag; a design that shared the enables or ignored the flag would insert data on the wrong line. Each payload is run in the other standard; a design that skipped the standard gating would insert aspect data on NTSC line 23 or copy data on PAL line 20. Every sample of each window is compared, including the first sample at WIN_START+1 and the sample just after the last bit, so an off-by-one start, a wrong bit length, LSB-first order or a missing start pattern each shows up as a mismatched sample.

// File: rtl/vbi_ins_pkg.sv
package vbi_ins_pkg;

    localparam int COPY_BITS  = 20;
    localparam int WIDE_BITS  = 14;
    localparam int START_BITS = 2;
    localparam logic [START_BITS-1:0] START_PAT = 2'b10;
    localparam int FRAME_MAX  = START_BITS + COPY_BITS;

    localparam int COPY_LINE_ODD  = 20;
    localparam int COPY_LINE_EVEN = 283;
    localparam int WIDE_LINE      = 23;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_COPY = 2'd1,
        ST_WIDE = 2'd2
    } ser_state_t;

    typedef struct packed {
        logic                 en_odd;
        logic                 en_even;
        logic                 en_wide;
        logic [COPY_BITS-1:0] copy;
        logic [WIDE_BITS-1:0] wide;
    } vbi_cfg_t;

endpackage

// File: rtl/vbi_cfg_regs.sv
module vbi_cfg_regs
    import vbi_ins_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       field_start,
    output vbi_cfg_t   act_cfg
);

    vbi_cfg_t shadow_q;

    // R2: byte writes land in the shadow set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                3'd0: begin
                    shadow_q.en_odd     <= wr_data[0];
                    shadow_q.en_even    <= wr_data[1];
                    shadow_q.en_wide    <= wr_data[2];
                    shadow_q.copy[3:0]  <= wr_data[7:4];
                end
                3'd1: shadow_q.copy[11:4]  <= wr_data;
                3'd2: shadow_q.copy[19:12] <= wr_data;
                3'd3: shadow_q.wide[7:0]   <= wr_data;
                3'd4: shadow_q.wide[13:8]  <= wr_data[5:0];
                default: ;
            endcase
        end
    end

    // R3: active set follows the shadow only at a field boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_cfg <= '0;
        end else if (field_start) begin
            act_cfg <= shadow_q;
        end
    end

endmodule

// File: rtl/vbi_line_sel.sv
module vbi_line_sel
    import vbi_ins_pkg::*;
#(
    parameter int LINE_W = 10,
    parameter int HCNT_W = 11,
    parameter int WIN_START = 200
)(
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_odd,
    input  logic              pal_mode,
    input  logic [HCNT_W-1:0] hcount,
    input  vbi_cfg_t          act_cfg,
    output logic              go_copy,
    output logic              go_wide
);

    localparam logic [LINE_W-1:0] L_ODD  = LINE_W'(COPY_LINE_ODD);
    localparam logic [LINE_W-1:0] L_EVEN = LINE_W'(COPY_LINE_EVEN);
    localparam logic [LINE_W-1:0] L_WIDE = LINE_W'(WIDE_LINE);
    localparam logic [HCNT_W-1:0] H_TRIG = HCNT_W'(WIN_START);

    logic at_trig, odd_hit, even_hit;

    always_comb begin
        at_trig  = (hcount == H_TRIG);
        // R4, R11: odd-field line
        odd_hit  = (line_num == L_ODD) && field_odd && act_cfg.en_odd;
        // R5, R11: even-field line
        even_hit = (line_num == L_EVEN) && !field_odd && act_cfg.en_even;
        // R8: each payload gated by the standard
        go_copy  = at_trig && !pal_mode && (odd_hit || even_hit);
        go_wide  = at_trig && pal_mode && (line_num == L_WIDE) && act_cfg.en_wide;
    end

endmodule

// File: rtl/vbi_serializer.sv
module vbi_serializer
    import vbi_ins_pkg::*;
#(
    parameter int BIT_CLKS = 16
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go_copy,
    input  logic                 go_wide,
    input  logic [COPY_BITS-1:0] copy_word,
    input  logic [WIDE_BITS-1:0] wide_word,
    output ser_state_t           state_o,
    output logic                 busy,
    output logic                 bit_val
);

    localparam int CLK_W  = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam int BITS_W = $clog2(FRAME_MAX + 1);
    localparam logic [CLK_W-1:0]  CLK_LAST = CLK_W'(BIT_CLKS - 1);
    localparam logic [BITS_W-1:0] N_COPY   = BITS_W'(FRAME_MAX);
    localparam logic [BITS_W-1:0] N_WIDE   = BITS_W'(WIDE_BITS);

    ser_state_t           state_q, state_d;
    logic [FRAME_MAX-1:0] sh_q;
    logic [CLK_W-1:0]     clk_q;
    logic [BITS_W-1:0]    left_q;
    logic                 bit_end, last_bit;

    assign bit_end  = (clk_q == CLK_LAST);
    assign last_bit = bit_end && (left_q == BITS_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_copy)      state_d = ST_COPY;
                else if (go_wide) state_d = ST_WIDE;
            end
            ST_COPY: if (last_bit) state_d = ST_IDLE;
            ST_WIDE: if (last_bit) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath: shifter and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            clk_q  <= '0;
            left_q <= '0;
        end else if (state_q == ST_IDLE) begin
            clk_q <= '0;
            if (go_copy) begin
                sh_q   <= {START_PAT, copy_word};            // R6
                left_q <= N_COPY;
            end else if (go_wide) begin
                sh_q   <= {wide_word, {(FRAME_MAX-WIDE_BITS){1'b0}}}; // R7
                left_q <= N_WIDE;
            end
        end else if (bit_end) begin
            clk_q  <= '0;
            sh_q   <= {sh_q[FRAME_MAX-2:0], 1'b0};
            left_q <= left_q - BITS_W'(1);
        end else begin
            clk_q <= clk_q + CLK_W'(1);
        end
    end

    // outputs
    always_comb begin
        state_o = state_q;
        busy    = (state_q != ST_IDLE);
        bit_val = sh_q[FRAME_MAX-1];
    end

endmodule

// File: rtl/vbi_copy_aspect_ins.sv
module vbi_copy_aspect_ins
    import vbi_ins_pkg::*;
#(
    parameter int LINE_W    = 10,
    parameter int HCNT_W    = 11,
    parameter int PIX_W     = 8,
    parameter int WIN_START = 200,
    parameter int BIT_CLKS  = 16,
    parameter int LVL_HI    = 169,
    parameter int LVL_LO    = 16
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              field_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_odd,
    input  logic              pal_mode,
    input  logic [HCNT_W-1:0] hcount,
    input  logic [PIX_W-1:0]  luma_in,
    output logic [PIX_W-1:0]  luma_out
);

    vbi_cfg_t   act_cfg;
    ser_state_t ser_st;
    logic       go_copy, go_wide, busy, bit_val;

    vbi_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .field_start(field_start), .act_cfg(act_cfg)
    );

    vbi_line_sel #(.LINE_W(LINE_W), .HCNT_W(HCNT_W), .WIN_START(WIN_START)) u_sel (
        .line_num(line_num), .field_odd(field_odd), .pal_mode(pal_mode),
        .hcount(hcount), .act_cfg(act_cfg), .go_copy(go_copy), .go_wide(go_wide)
    );

    vbi_serializer #(.BIT_CLKS(BIT_CLKS)) u_ser (
        .clk(clk), .rst_n(rst_n), .go_copy(go_copy), .go_wide(go_wide),
        .copy_word(act_cfg.copy), .wide_word(act_cfg.wide),
        .state_o(ser_st), .busy(busy), .bit_val(bit_val)
    );

    // R9, R10: level generation or pass-through
    always_comb begin
        if (busy) luma_out = bit_val ? PIX_W'(LVL_HI) : PIX_W'(LVL_LO);
        else      luma_out = luma_in;
    end

endmodule

// File: rtl/vbi_copy_aspect_chk.sv
module vbi_copy_aspect_chk
    import vbi_ins_pkg::*;
#(
    parameter int LINE_W = 10,
    parameter int PIX_W  = 8,
    parameter int LVL_HI = 169,
    parameter int LVL_LO = 16
)(
    input logic              clk,
    input logic              rst_n,
    input logic              field_start,
    input logic [LINE_W-1:0] line_num,
    input logic              field_odd,
    input logic              pal_mode,
    input logic [PIX_W-1:0]  luma_in,
    input logic [PIX_W-1:0]  luma_out,
    input ser_state_t        st,
    input vbi_cfg_t          act
);

    assert_two_levels_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (luma_out != luma_in) |-> (luma_out == PIX_W'(LVL_HI) || luma_out == PIX_W'(LVL_LO)));

    assert_cfg_at_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act) |-> $past(field_start));

    // R4 / R5 / R11: copy frame starts only on an enabled line of the right field
    assert_copy_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COPY && $past(st) == ST_IDLE) |->
            $past(!pal_mode && ((line_num == LINE_W'(COPY_LINE_ODD) && field_odd && act.en_odd) ||
                                (line_num == LINE_W'(COPY_LINE_EVEN) && !field_odd && act.en_even))));

    assert_wide_pal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WIDE && $past(st) == ST_IDLE) |->
            $past(pal_mode && line_num == LINE_W'(WIDE_LINE) && act.en_wide));

endmodule

bind vbi_copy_aspect_ins vbi_copy_aspect_chk #(
    .LINE_W(LINE_W), .PIX_W(PIX_W), .LVL_HI(LVL_HI), .LVL_LO(LVL_LO)
) u_chk (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .line_num(line_num),
    .field_odd(field_odd), .pal_mode(pal_mode), .luma_in(luma_in),
    .luma_out(luma_out), .st(ser_st), .act(act_cfg)
);

// File: tb/sim_vbi_copy_aspect_ins.sv
`timescale 1ns/1ps
module sim_vbi_copy_aspect_ins;

    localparam int WIN  = 200;
    localparam int BCK  = 16;
    localparam int HI   = 169;
    localparam int LO   = 16;
    localparam real TCK = 4.0;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       wr_en = 0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       field_start = 0;
    logic [9:0] line_num = '0;
    logic       field_odd = 0;
    logic       pal_mode = 0;
    logic [10:0] hcount = '0;
    logic [7:0] luma_in = '0;
    logic [7:0] luma_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(TCK/2) clk = ~clk;

    vbi_copy_aspect_ins u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .field_start(field_start), .line_num(line_num),
        .field_odd(field_odd), .pal_mode(pal_mode), .hcount(hcount),
        .luma_in(luma_in), .luma_out(luma_out)
    );

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic new_field();
        @(negedge clk); field_start = 1;
        @(negedge clk); field_start = 0;
    endtask

    // Runs one line; nbits==0 means pure pass-through expected.
    task automatic run_line(input string req, input int ln, input bit odd, input bit pal,
                            input int nbits, input logic [21:0] stream);
        int errs = 0;
        int a_h = 0, a_got = 0, a_exp = 0;
        line_num = 10'(ln); field_odd = odd; pal_mode = pal;
        for (int h = 0; h < WIN + 22*BCK + 12; h++) begin
            int expv, s;
            @(negedge clk);
            hcount  = 11'(h);
            luma_in = 8'(h * 7 + 3);
            #1;
            s = h - (WIN + 1);
            if (nbits > 0 && s >= 0 && s < nbits*BCK)
                expv = stream[nbits - 1 - s/BCK] ? HI : LO;
            else
                expv = int'(luma_in);
            if (int'(luma_out) != expv) begin
                if (errs == 0) begin a_h = h; a_got = int'(luma_out); a_exp = expv; end
                errs++;
            end
        end
        total++;
        if (errs != 0) begin
            bad++;
            $display("FAIL %s line=%0d hcount=%0d got=%0d exp=%0d (%0d bad samples)",
                     req, ln, a_h, a_got, a_exp, errs);
        end
        @(negedge clk); hcount = '0; line_num = 10'd400;
    endtask

    task automatic t_reset();
        run_line("R1", 20, 1, 0, 0, '0);
        run_line("R1", 283, 0, 0, 0, '0);
        run_line("R1", 23, 1, 1, 0, '0);
    endtask

    task automatic t_copy_odd();
        // copy = 20'h9C3A5: ctrl bits7:4 = 5, en_odd
        wr(3'd0, 8'h51); wr(3'd1, 8'hA5 >> 4 | 8'hC0); // placeholder overwritten below
        wr(3'd1, 8'h3A); wr(3'd2, 8'h9C);
        // R3: not yet active in this field
        run_line("R3", 20, 1, 0, 0, '0);
        new_field();
        // R2 R4 R6 R9: start 10 then 20'h9C3A5
        run_line("R4", 20, 1, 0, 22, {2'b10, 20'h9C3A5});
        run_line("R10", 100, 1, 0, 0, '0);
        run_line("R11", 20, 0, 0, 0, '0);
        run_line("R5", 283, 0, 0, 0, '0);
    endtask

    task automatic t_copy_even();
        wr(3'd0, 8'h52);                    // even only, low nibble 5
        wr(3'd1, 8'hF0); wr(3'd2, 8'h0E);   // copy = 20'h0EF05
        new_field();
        run_line("R5", 283, 0, 0, 22, {2'b10, 20'h0EF05});
        run_line("R5", 20, 1, 0, 0, '0);
        run_line("R11", 283, 1, 0, 0, '0);
        run_line("R8", 20, 1, 1, 0, '0);
        // R3: mid-field payload change held back
        wr(3'd2, 8'hB1);
        run_line("R3", 283, 0, 0, 22, {2'b10, 20'h0EF05});
        new_field();
        run_line("R6", 283, 0, 0, 22, {2'b10, 20'hB1F05});
    endtask

    task automatic t_wide();
        wr(3'd0, 8'h07);                    // all enables, copy low nibble 0
        wr(3'd3, 8'h6D); wr(3'd4, 8'hE9);   // wide = 14'h296D (bits7:6 dropped)
        new_field();
        run_line("R7", 23, 1, 1, 14, {8'h00, 14'h296D});
        run_line("R7", 23, 0, 1, 14, {8'h00, 14'h296D});
        run_line("R8", 23, 1, 0, 0, '0);
        run_line("R8", 283, 0, 1, 0, '0);
        run_line("R4", 20, 1, 0, 22, {2'b10, 20'hB1F00});
        run_line("R10", 24, 1, 1, 0, '0);
    endtask

    initial begin
        #(TCK * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        line_num = 10'd400;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_copy_odd();
        t_copy_even();
        t_wide();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule